// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare and Interval Timers

This peripheral keeps time from a slow tick enable that runs at 32768 pulses per second, so that the whole-second count is the elapsed count shifted right by 15. It holds a 48-bit free-running elapsed counter, a 48-bit compare value and two 32-bit periodic interval timers. Each timer has a programmable cycle length and a current count that software can read.

Software reaches every wide value through 16-bit slices on a simple register bus. Writes take effect on the clock edge. Reads are combinational and live: they are not latched, so a slice may change between the reads of two slices. Four event sources set bits in a shared status register. Software clears each bit by writing 1 to it, and the interrupt output is asserted while any bit is set.

Top module: `etm_top`

## Requirements
- R1: After reset the elapsed counter, compare value, timer cycle values, timer counts and status register all read 0, and `irq_o` is low.
- R2: The elapsed counter adds one on each cycle with `tick_i` high and otherwise holds. Reads of offsets 0x00, 0x02 and 0x04 return its bits 15:0, 31:16 and 47:32, taken live.
- R3: A write to 0x00, 0x02 or 0x04 loads that 16-bit slice of the elapsed counter and leaves the other slices alone.
- R4: The compare value is written and read at 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32). Status bit 0 is set on the tick edge at which the counter becomes equal to all 48 bits of the compare value.
- R5: Timer 1 takes its cycle value at 0x10 (low) and 0x12 (high) and shows its count at 0x14 (low) and 0x16 (high). A write to either cycle half loads the count with the new cycle value. Each tick lowers the count by one. A tick that finds the count at 1 or below reloads the cycle value and sets status bit 1, so the period is the cycle value in ticks.
- R6: Timer 2 behaves like timer 1. Its cycle value is at 0x18 and 0x1A, its count is at 0x1C and 0x1E, and it sets status bit 2.
- R7: A timer whose cycle value is 0 holds its count at 0 and raises no event.
- R8: A one-cycle pulse on `ext_evt_i` sets status bit 3.
- R9: The status register reads at 0x20 in bits 3:0. Writing 1 to a bit clears it and writing 0 has no effect. A bit that is set in the same cycle as a clearing write stays set.
- R10: `irq_o` is the OR of the four status bits.
- R11: Offsets with no register, including odd offsets, 0x06, 0x0E and any offset above 0x20, read 0. Writes to them change no register.
- R12: The elapsed counter wraps from all ones to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz count enable, one cycle wide |
| ext_evt_i | input | 1 | Clock-timer event pulse, sets status bit 3 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, OR of the status bits |

## Verification
The counter is preset below the compare value and ticked up to it, so that a match fired one tick early or late shows up in the status read. A second compare differs from the counter only in its top slice, which catches a match that looks at fewer than 48 bits. Timer 1 uses a three-tick period and timer 2 uses both a two-tick period and a cycle value of 0x10000, which separates reload, period and half-word carry errors, and cycle 0 shows whether the disable works. The status register is hit with a set and a clear in the same cycle and with writes of 0, while writes to unmapped offsets are followed by reads of every register they could have corrupted.

// File: rtl/etm_pkg.sv
package etm_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 16;
  localparam int ET_W     = 48;
  localparam int TM_W     = 32;
  localparam int N_TM     = 2;
  localparam int N_EVT    = 4;
  localparam int ET_SL    = ET_W / DATA_W;
  localparam int TM_SL    = TM_W / DATA_W;
  // byte offsets
  localparam int OFF_ET   = 'h00;
  localparam int OFF_CMP  = 'h08;
  localparam int OFF_TM   = 'h10;
  localparam int TM_STEP  = 'h08;
  localparam int TM_CNT   = 'h04;
  localparam int OFF_STAT = 'h20;
  // status bit positions
  localparam int EVT_CMP  = 0;
  localparam int EVT_TM0  = 1;
  localparam int EVT_EXT  = 3;
endpackage

// File: rtl/etm_elapsed.sv
module etm_elapsed
  import etm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ET_SL-1:0]  cnt_we_i,
  input  logic [ET_SL-1:0]  cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ET_W-1:0]   cnt_o,
  output logic [ET_W-1:0]   cmp_o,
  output logic              match_o
);
  logic [ET_W-1:0] cnt_q, cmp_q, cnt_inc, cnt_d, cmp_d;

  assign cnt_inc = cnt_q + ET_W'(tick_i);

  always_comb begin
    cnt_d = cnt_inc;
    cmp_d = cmp_q;
    for (int i = 0; i < ET_SL; i++) begin
      if (cnt_we_i[i]) cnt_d[i*DATA_W +: DATA_W] = wdata_i;
      if (cmp_we_i[i]) cmp_d[i*DATA_W +: DATA_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  // hit on the tick that lands on the compare value
  assign match_o = tick_i && (cnt_inc == cmp_q);
  assign cnt_o   = cnt_q;
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/etm_interval.sv
module etm_interval
  import etm_pkg::*;
#(
  parameter int W  = TM_W,
  localparam int SL = W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [SL-1:0]     cyc_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [W-1:0]      cyc_o,
  output logic [W-1:0]      cnt_o,
  output logic              evt_o
);
  logic [W-1:0] cyc_q, cnt_q, cyc_nx;
  logic         run, wrap;

  always_comb begin
    cyc_nx = cyc_q;
    for (int i = 0; i < SL; i++)
      if (cyc_we_i[i]) cyc_nx[i*DATA_W +: DATA_W] = wdata_i;
  end

  assign run  = tick_i && (cyc_q != '0) && !(|cyc_we_i);
  assign wrap = cnt_q <= W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else if (|cyc_we_i) begin
      cyc_q <= cyc_nx;
      cnt_q <= cyc_nx;
    end else if (run) begin
      cnt_q <= wrap ? cyc_q : cnt_q - W'(1);
    end
  end

  assign evt_o = run && wrap;
  assign cyc_o = cyc_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/etm_irq.sv
module etm_irq #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_m) | set_i;  // set beats clear
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
endmodule

// File: rtl/etm_top.sv
module etm_top
  import etm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_evt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [ET_SL-1:0]                et_we, cmp_we;
  logic [ET_W-1:0]                 et_cnt, et_cmp;
  logic                            et_hit;
  logic [N_TM-1:0][TM_SL-1:0]      tm_we;
  logic [N_TM-1:0][TM_W-1:0]       tm_cyc, tm_cnt;
  logic [N_TM-1:0]                 tm_evt;
  logic [N_EVT-1:0]                evt_vec, status_q;
  logic                            stat_we;

  for (genvar i = 0; i < ET_SL; i++) begin : g_et_dec
    assign et_we[i]  = we_i && (addr_i == ADDR_W'(OFF_ET  + 2*i));
    assign cmp_we[i] = we_i && (addr_i == ADDR_W'(OFF_CMP + 2*i));
  end

  etm_elapsed u_elapsed (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_we_i (et_we),
    .cmp_we_i (cmp_we),
    .wdata_i  (wdata_i),
    .cnt_o    (et_cnt),
    .cmp_o    (et_cmp),
    .match_o  (et_hit)
  );

  for (genvar k = 0; k < N_TM; k++) begin : g_tm
    for (genvar h = 0; h < TM_SL; h++) begin : g_dec
      assign tm_we[k][h] = we_i && (addr_i == ADDR_W'(OFF_TM + TM_STEP*k + 2*h));
    end
    etm_interval #(.W(TM_W)) u_tm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .cyc_we_i (tm_we[k]),
      .wdata_i  (wdata_i),
      .cyc_o    (tm_cyc[k]),
      .cnt_o    (tm_cnt[k]),
      .evt_o    (tm_evt[k])
    );
    assign evt_vec[EVT_TM0 + k] = tm_evt[k];
  end

  assign evt_vec[EVT_CMP] = et_hit;
  assign evt_vec[EVT_EXT] = ext_evt_i;
  assign stat_we          = we_i && (addr_i == ADDR_W'(OFF_STAT));

  etm_irq #(.N(N_EVT)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_vec),
    .clr_we_i (stat_we),
    .clr_i    (wdata_i[N_EVT-1:0]),
    .status_o (status_q),
    .irq_o    (irq_o)
  );

  // live read mux; unmapped offsets return zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < ET_SL; i++) begin
      if (addr_i == ADDR_W'(OFF_ET  + 2*i)) rdata_o = et_cnt[i*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(OFF_CMP + 2*i)) rdata_o = et_cmp[i*DATA_W +: DATA_W];
    end
    for (int k = 0; k < N_TM; k++) begin
      for (int h = 0; h < TM_SL; h++) begin
        if (addr_i == ADDR_W'(OFF_TM + TM_STEP*k + 2*h))
          rdata_o = tm_cyc[k][h*DATA_W +: DATA_W];
        if (addr_i == ADDR_W'(OFF_TM + TM_STEP*k + TM_CNT + 2*h))
          rdata_o = tm_cnt[k][h*DATA_W +: DATA_W];
      end
    end
    if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = DATA_W'(status_q);
  end
endmodule

// File: rtl/etm_chk.sv
module etm_chk
  import etm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             we_i,
  input logic             irq_o,
  input logic [ET_W-1:0]  et_cnt_i,
  input logic [N_EVT-1:0] status_i,
  input logic [N_EVT-1:0] set_i,
  input logic [TM_W-1:0]  cyc0_i,
  input logic [TM_W-1:0]  cnt0_i
);
  // R2
  et_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !we_i |=> et_cnt_i == $past(et_cnt_i));
  // R2
  et_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !we_i |=> et_cnt_i == ET_W'($past(et_cnt_i) + ET_W'(1)));
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> (status_i & $past(set_i)) == $past(set_i));
  // R10
  irq_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|status_i));
  // R7
  tm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc0_i == '0 |-> cnt0_i == '0);
  // R5
  tm_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt0_i <= cyc0_i);
endmodule

bind etm_top etm_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .we_i     (we_i),
  .irq_o    (irq_o),
  .et_cnt_i (et_cnt),
  .status_i (status_q),
  .set_i    (evt_vec),
  .cyc0_i   (tm_cyc[0]),
  .cnt0_i   (tm_cnt[0])
);

// File: tb/etm_top_bench.sv
`timescale 1ns/1ps
module etm_top_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, ext_evt_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  etm_top u_etm_top (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ext_evt_i(ext_evt_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam logic [1:0] OW = 2'd0, OT = 2'd1, OC = 2'd2;
  localparam int N_STEPS = 49;
  // {op, addr, value, requirement}
  localparam logic [31:0] STEPS [N_STEPS] = '{
    {OW, 6'h00, 16'h0005, 8'd3},  // R3 preset
    {OC, 6'h00, 16'h0005, 8'd3},
    {OW, 6'h08, 16'h0008, 8'd4},  // R4 compare
    {OC, 6'h08, 16'h0008, 8'd4},
    {OT, 6'h00, 16'd2,    8'd2},  // R2 count
    {OC, 6'h00, 16'h0007, 8'd2},
    {OC, 6'h20, 16'h0000, 8'd4},
    {OT, 6'h00, 16'd1,    8'd4},
    {OC, 6'h00, 16'h0008, 8'd2},
    {OC, 6'h20, 16'h0001, 8'd4},  // match on reaching 8
    {OW, 6'h20, 16'h0001, 8'd9},  // R9 clear
    {OC, 6'h20, 16'h0000, 8'd9},
    {OW, 6'h10, 16'h0003, 8'd5},  // R5 timer 1 period 3
    {OC, 6'h14, 16'h0003, 8'd5},
    {OT, 6'h00, 16'd2,    8'd5},
    {OC, 6'h14, 16'h0001, 8'd5},
    {OC, 6'h20, 16'h0000, 8'd5},
    {OT, 6'h00, 16'd1,    8'd5},
    {OC, 6'h14, 16'h0003, 8'd5},
    {OC, 6'h20, 16'h0002, 8'd5},
    {OW, 6'h20, 16'h0002, 8'd9},
    {OW, 6'h1A, 16'h0001, 8'd6},  // R6 timer 2 cycle 0x10000
    {OC, 6'h1E, 16'h0001, 8'd6},
    {OC, 6'h1C, 16'h0000, 8'd6},
    {OT, 6'h00, 16'd1,    8'd6},
    {OC, 6'h1C, 16'hFFFF, 8'd6},
    {OC, 6'h1E, 16'h0000, 8'd6},
    {OW, 6'h1A, 16'h0000, 8'd7},  // R7 cycle 0
    {OC, 6'h1C, 16'h0000, 8'd7},
    {OW, 6'h18, 16'h0002, 8'd6},
    {OT, 6'h00, 16'd2,    8'd6},
    {OC, 6'h20, 16'h0006, 8'd6},  // both timers fire
    {OW, 6'h20, 16'h000F, 8'd9},
    {OW, 6'h10, 16'h0000, 8'd7},
    {OW, 6'h18, 16'h0000, 8'd7},
    {OT, 6'h00, 16'd5,    8'd7},
    {OC, 6'h14, 16'h0000, 8'd7},
    {OC, 6'h1C, 16'h0000, 8'd7},
    {OC, 6'h20, 16'h0000, 8'd7},
    {OW, 6'h06, 16'h1234, 8'd11}, // R11 unmapped
    {OC, 6'h06, 16'h0000, 8'd11},
    {OC, 6'h22, 16'h0000, 8'd11},
    {OW, 6'h0E, 16'h5555, 8'd11},
    {OC, 6'h0E, 16'h0000, 8'd11},
    {OC, 6'h08, 16'h0008, 8'd11},
    {OC, 6'h00, 16'h0013, 8'd2},
    {OW, 6'h04, 16'h00AB, 8'd3},
    {OC, 6'h04, 16'h00AB, 8'd3},
    {OC, 6'h02, 16'h0000, 8'd3}
  };

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic chk(input logic [5:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); addr_i = a; #1;
    checks++;
    if (rdata_o !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata_o, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk); #1;
    checks++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq_o, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk(6'h00, 16'h0000, "R1");
    chk(6'h08, 16'h0000, "R1");
    chk(6'h10, 16'h0000, "R1");
    chk(6'h14, 16'h0000, "R1");
    chk(6'h20, 16'h0000, "R1");
    chk_irq(1'b0, "R1");

    for (int s = 0; s < N_STEPS; s++) begin
      logic [1:0] op; logic [5:0] a; logic [15:0] v; string rq;
      {op, a, v} = STEPS[s][31:8];
      rq = $sformatf("R%0d", STEPS[s][7:0]);
      case (op)
        OW:      wr(a, v);
        OT:      ticks(int'(v));
        default: chk(a, v, rq);
      endcase
    end

    // R12 wrap
    wr(6'h00, 16'hFFFF); wr(6'h02, 16'hFFFF); wr(6'h04, 16'hFFFF);
    ticks(1);
    chk(6'h00, 16'h0000, "R12");
    chk(6'h02, 16'h0000, "R12");
    chk(6'h04, 16'h0000, "R12");

    // R4 all 48 bits compared
    wr(6'h08, 16'h0005); wr(6'h0A, 16'h0000); wr(6'h0C, 16'h0001);
    wr(6'h00, 16'h0004);
    ticks(1);
    chk(6'h00, 16'h0005, "R4");
    chk(6'h20, 16'h0000, "R4");

    // R8 / R10 external event
    @(negedge clk); ext_evt_i = 1'b1;
    @(negedge clk); ext_evt_i = 1'b0;
    chk(6'h20, 16'h0008, "R8");
    chk_irq(1'b1, "R10");
    // R9 zero bits leave status alone
    wr(6'h20, 16'h0007);
    chk(6'h20, 16'h0008, "R9");
    // R9 set in the clearing cycle wins
    @(negedge clk); ext_evt_i = 1'b1; we_i = 1'b1; addr_i = 6'h20; wdata_i = 16'h0008;
    @(negedge clk); ext_evt_i = 1'b0; we_i = 1'b0;
    chk(6'h20, 16'h0008, "R9");
    wr(6'h20, 16'h0008);
    chk(6'h20, 16'h0000, "R9");
    chk_irq(1'b0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule